// File: doc/BRIEF.md
# Multi-Channel Inter-Processor Mailbox

This block is a memory-mapped mailbox through which processors pass 32-bit messages to one another. It contains a set of small message queues. Any processor may push a word into a queue by writing that queue's message word, and another processor pops it by reading the same word. Per-queue occupancy and fullness are visible as read-only words.

Each user (an interrupt consumer) has its own event status word and its own enable word. Two events are tracked per queue: a word was pushed, and a pop freed space in a full queue. A user's interrupt line is high while any enabled event of that user is pending. Software clears pending events by writing ones.

The configuration word holds two plain idle-control fields and a self-clearing soft reset bit. A status word reports when the soft reset has finished, and a constant revision word identifies the block. Access is through a simple synchronous register bus with a one-cycle registered read.

Top module: `ipc_mailbox`

## Requirements
- R1: After the reset input, every queue is empty, all event status and enable words read 0, all interrupt lines are low, the reset-done flag (bit 0 of the word at 0x014) reads 1, and the word at 0x000 reads 0x10 (major revision 1 in bits 7:4, minor revision 0 in bits 3:0).
- R2: Byte addresses are word aligned. Reads of any address that is not a mapped word, whether below or at and above 0x120, return 0. Writes to read-only words (revision, reset status, queue status words) have no effect.
- R3: A write to 0x040+4m pushes the write data into queue m, and a read of that address pops the oldest word. Words leave in the order they entered. The word at 0x0C0+4m reads the number of queued words, and bit 0 of the word at 0x080+4m reads 1 exactly when queue m holds 4 words.
- R4: A push into a full queue is dropped and leaves its contents unchanged. A pop from an empty queue returns 0 and changes nothing.
- R5: In the status word of user u at 0x100+8u, bit 2m is set for every user on each accepted push into queue m. Bit 2m+1 is set when a pop takes queue m from full to not full. Both bits stay set until software clears them.
- R6: Writing a 1 to a status bit clears it, and writing a 0 leaves it unchanged. A status write for one user does not touch any other user's status.
- R7: The enable word of user u lies at 0x104+8u with the same bit layout as the status word. Interrupt line u is high exactly while status AND enable of user u is nonzero, and it follows a change of status or enable in the same cycle as the register change.
- R8: Writing 1 to bit 1 of the configuration word at 0x010 starts a soft reset. Bit 1 reads 1 and the reset-done flag reads 0 for 4 cycles. Then bit 1 clears and the done flag returns to 1. The soft reset empties all queues and clears all status and enable words.
- R9: Configuration bit 0 (auto-idle) and bits 4:3 (idle mode) are plain read/write storage that the soft reset preserves. Every other configuration bit except the reset bit reads 0.
- R10: Read data is registered. It updates at the clock edge that samples the read strobe and holds its value until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 9 | Byte address of the accessed word |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per read (pops a message word) |
| bus_rdata | output | 32 | Registered read data |
| user_irq | output | N_USER (2) | Interrupt line per user |

## Verification
A read result lands in the data register at the edge that samples the strobe. The bench drives each access at a falling edge and samples at the next falling edge, so every read check sees exactly one edge. Status, enable and queue state change at the write edge, and the interrupt lines are combinational from them, so an interrupt check made one falling edge after a write sees the new level. The soft reset runs 4 edges after the requesting write. The bench therefore expects four reads of the done flag to return 0 and the fifth to return 1.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

    localparam int DATA_W    = 32;
    localparam int ADDR_W    = 9;
    localparam int SPAN      = 'h120;

    localparam int OFS_REV   = 'h000;
    localparam int OFS_CFG   = 'h010;
    localparam int OFS_STAT  = 'h014;
    localparam int OFS_MSG   = 'h040;
    localparam int OFS_FULL  = 'h080;
    localparam int OFS_LEVEL = 'h0C0;
    localparam int OFS_USER  = 'h100;

    localparam int CFG_AUTOIDLE = 0;
    localparam int CFG_SRST     = 1;
    localparam int CFG_IDLE_LO  = 3;

    typedef enum logic [3:0] {
        SEL_NONE,
        SEL_REV,
        SEL_CFG,
        SEL_STAT,
        SEL_MSG,
        SEL_FULL,
        SEL_LEVEL,
        SEL_EVT,
        SEL_ENA
    } reg_sel_e;

    typedef struct packed {
        reg_sel_e   sel;
        logic [3:0] idx;
    } reg_dec_t;

    function automatic reg_dec_t decode_addr(input logic [ADDR_W-1:0] a,
                                             input int n_mbox,
                                             input int n_user);
        reg_dec_t d;
        int ai;
        ai = int'({23'b0, a}) & ~3;
        d.sel = SEL_NONE;
        d.idx = '0;
        if (ai == OFS_REV) begin
            d.sel = SEL_REV;
        end else if (ai == OFS_CFG) begin
            d.sel = SEL_CFG;
        end else if (ai == OFS_STAT) begin
            d.sel = SEL_STAT;
        end else if (ai >= OFS_MSG && ai < OFS_MSG + 4 * n_mbox) begin
            d.sel = SEL_MSG;
            d.idx = 4'((ai - OFS_MSG) >> 2);
        end else if (ai >= OFS_FULL && ai < OFS_FULL + 4 * n_mbox) begin
            d.sel = SEL_FULL;
            d.idx = 4'((ai - OFS_FULL) >> 2);
        end else if (ai >= OFS_LEVEL && ai < OFS_LEVEL + 4 * n_mbox) begin
            d.sel = SEL_LEVEL;
            d.idx = 4'((ai - OFS_LEVEL) >> 2);
        end else if (ai >= OFS_USER && ai < OFS_USER + 8 * n_user && ai < SPAN) begin
            d.sel = ((ai - OFS_USER) & 4) != 0 ? SEL_ENA : SEL_EVT;
            d.idx = 4'((ai - OFS_USER) >> 3);
        end
        return d;
    endfunction

endpackage

// File: rtl/mbx_fifo.sv
module mbx_fifo #(
    parameter int DEPTH = 4,
    parameter int WIDTH = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push,
    input  logic             pop,
    input  logic [WIDTH-1:0] wdata,
    output logic [WIDTH-1:0] head,
    output logic [CNT_W-1:0] level,
    output logic             full,
    output logic             empty,
    output logic             push_ok,
    output logic             freed
);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wptr, rptr;
    logic             do_pop;

    assign full    = (level == CNT_W'(DEPTH));
    assign empty   = (level == '0);
    assign push_ok = push && !full;
    assign do_pop  = pop && !empty;
    assign freed   = do_pop && full;
    assign head    = empty ? '0 : mem[rptr];

    always_ff @(posedge clk) begin
        if (rst) begin
            wptr  <= '0;
            rptr  <= '0;
            level <= '0;
        end else begin
            if (push_ok) begin
                mem[wptr] <= wdata;
                wptr      <= (wptr == PTR_W'(DEPTH - 1)) ? '0 : wptr + 1'b1;
            end
            if (do_pop) begin
                rptr <= (rptr == PTR_W'(DEPTH - 1)) ? '0 : rptr + 1'b1;
            end
            if (push_ok && !do_pop) begin
                level <= level + 1'b1;
            end else if (do_pop && !push_ok) begin
                level <= level - 1'b1;
            end
        end
    end

    // R4: occupancy never exceeds the depth
    a_r4_level_bound: assert property (@(posedge clk) disable iff (rst)
        level <= CNT_W'(DEPTH));

    // R4: a push into a full queue is dropped
    a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> full);

    // R4: a pop from an empty queue changes nothing
    a_r4_empty_pop: assert property (@(posedge clk) disable iff (rst)
        (empty && pop && !push) |=> empty);

endmodule

// File: rtl/mbx_irq.sv
module mbx_irq #(
    parameter int N_MBOX = 4,
    localparam int EV_W = 2 * N_MBOX
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [N_MBOX-1:0] new_ev,
    input  logic [N_MBOX-1:0] free_ev,
    input  logic            evt_wr,
    input  logic            ena_wr,
    input  logic [EV_W-1:0] wdata,
    output logic [EV_W-1:0] evt,
    output logic [EV_W-1:0] ena,
    output logic            irq
);

    logic [EV_W-1:0] set_vec;
    logic [EV_W-1:0] clr_vec;

    for (genvar m = 0; m < N_MBOX; m++) begin : g_lane
        assign set_vec[2*m]     = new_ev[m];
        assign set_vec[2*m + 1] = free_ev[m];
    end

    assign clr_vec = evt_wr ? wdata : '0;
    assign irq     = |(evt & ena);

    always_ff @(posedge clk) begin
        if (rst) begin
            evt <= '0;
            ena <= '0;
        end else begin
            evt <= (evt & ~clr_vec) | set_vec;
            if (ena_wr) begin
                ena <= wdata;
            end
        end
    end

    // R5: pending events stay set unless a clearing write arrives
    a_r5_sticky: assert property (@(posedge clk) disable iff (rst)
        !evt_wr |=> ((evt & $past(evt)) == $past(evt)));

    // R6: written ones clear the addressed bits when no event competes
    a_r6_w1c: assert property (@(posedge clk) disable iff (rst)
        (evt_wr && set_vec == '0) |=> ((evt & $past(wdata)) == '0));

endmodule

// File: rtl/mbx_sysctl.sv
module mbx_sysctl #(
    parameter int SRST_CYCLES = 4,
    localparam int CNT_W = (SRST_CYCLES > 2) ? $clog2(SRST_CYCLES) : 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_wr,
    input  logic       wr_autoidle,
    input  logic       wr_srst,
    input  logic [1:0] wr_idle,
    output logic       autoidle,
    output logic [1:0] idle_mode,
    output logic       busy,
    output logic       done
);

    localparam logic [CNT_W-1:0] LAST = CNT_W'(SRST_CYCLES - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy      <= 1'b0;
            done      <= 1'b1;
            cnt       <= '0;
            autoidle  <= 1'b0;
            idle_mode <= '0;
        end else begin
            if (busy) begin
                if (cnt == LAST) begin
                    busy <= 1'b0;
                    done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
            if (cfg_wr) begin
                autoidle  <= wr_autoidle;
                idle_mode <= wr_idle;
                if (wr_srst) begin
                    busy <= 1'b1;
                    done <= 1'b0;
                    cnt  <= '0;
                end
            end
        end
    end

    // R8: the done flag is low for the whole soft reset
    a_r8_done_low: assert property (@(posedge clk) disable iff (rst)
        busy |-> !done);

    // R8: at the end of the window the reset bit clears and done returns
    a_r8_finish: assert property (@(posedge clk) disable iff (rst)
        (busy && cnt == LAST && !(cfg_wr && wr_srst)) |=> (!busy && done));

    // R8: a request always enters the busy window
    a_r8_start: assert property (@(posedge clk) disable iff (rst)
        (cfg_wr && wr_srst) |=> (busy && !done));

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
    import mbx_pkg::*;
#(
    parameter int N_MBOX      = 4,
    parameter int N_USER      = 2,
    parameter int FIFO_DEPTH  = 4,
    parameter int SRST_CYCLES = 4,
    parameter int REV_MAJOR   = 1,
    parameter int REV_MINOR   = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_rd,
    output logic [DATA_W-1:0] bus_rdata,
    output logic [N_USER-1:0] user_irq
);

    localparam int EV_W  = 2 * N_MBOX;
    localparam int CNT_W = $clog2(FIFO_DEPTH + 1);
    localparam logic [DATA_W-1:0] REV_WORD =
        DATA_W'({REV_MAJOR[3:0], REV_MINOR[3:0]});

    reg_dec_t dec;
    logic     soft_busy, soft_done, autoidle;
    logic [1:0] idle_mode;
    logic     blk_rst;

    logic [DATA_W-1:0] head  [N_MBOX];
    logic [CNT_W-1:0]  level [N_MBOX];
    logic [N_MBOX-1:0] full, empty, push_ok, freed;
    logic [EV_W-1:0]   evt [N_USER];
    logic [EV_W-1:0]   ena [N_USER];
    logic [DATA_W-1:0] rd_mux;

    assign dec     = decode_addr(bus_addr, N_MBOX, N_USER);
    assign blk_rst = rst || soft_busy;

    mbx_sysctl #(.SRST_CYCLES(SRST_CYCLES)) u_sysctl (
        .clk         (clk),
        .rst         (rst),
        .cfg_wr      (bus_wr && dec.sel == SEL_CFG),
        .wr_autoidle (bus_wdata[CFG_AUTOIDLE]),
        .wr_srst     (bus_wdata[CFG_SRST]),
        .wr_idle     (bus_wdata[CFG_IDLE_LO+1:CFG_IDLE_LO]),
        .autoidle    (autoidle),
        .idle_mode   (idle_mode),
        .busy        (soft_busy),
        .done        (soft_done)
    );

    for (genvar m = 0; m < N_MBOX; m++) begin : g_mbox
        mbx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(DATA_W)) u_fifo (
            .clk     (clk),
            .rst     (blk_rst),
            .push    (bus_wr && dec.sel == SEL_MSG && dec.idx == 4'(m)),
            .pop     (bus_rd && dec.sel == SEL_MSG && dec.idx == 4'(m)),
            .wdata   (bus_wdata),
            .head    (head[m]),
            .level   (level[m]),
            .full    (full[m]),
            .empty   (empty[m]),
            .push_ok (push_ok[m]),
            .freed   (freed[m])
        );
    end

    for (genvar u = 0; u < N_USER; u++) begin : g_user
        mbx_irq #(.N_MBOX(N_MBOX)) u_irq (
            .clk     (clk),
            .rst     (blk_rst),
            .new_ev  (push_ok),
            .free_ev (freed),
            .evt_wr  (bus_wr && dec.sel == SEL_EVT && dec.idx == 4'(u)),
            .ena_wr  (bus_wr && dec.sel == SEL_ENA && dec.idx == 4'(u)),
            .wdata   (bus_wdata[EV_W-1:0]),
            .evt     (evt[u]),
            .ena     (ena[u]),
            .irq     (user_irq[u])
        );
    end

    always_comb begin
        rd_mux = '0;
        unique case (dec.sel)
            SEL_REV:   rd_mux = REV_WORD;
            SEL_CFG:   rd_mux = DATA_W'({idle_mode, 1'b0, soft_busy, autoidle});
            SEL_STAT:  rd_mux = DATA_W'(soft_done);
            SEL_MSG:   rd_mux = head[dec.idx];
            SEL_FULL:  rd_mux = DATA_W'(full[dec.idx]);
            SEL_LEVEL: rd_mux = DATA_W'(level[dec.idx]);
            SEL_EVT:   rd_mux = DATA_W'(evt[dec.idx]);
            SEL_ENA:   rd_mux = DATA_W'(ena[dec.idx]);
            default:   rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            bus_rdata <= rd_mux;
        end
    end

    // R2: unmapped reads return zero
    a_r2_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && dec.sel == SEL_NONE) |=> (bus_rdata == '0));

    // R10: read data holds between reads
    a_r10_hold: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |=> $stable(bus_rdata));

    // R7: no interrupt during a soft reset window after its first cycle
    a_r7_quiet_in_srst: assert property (@(posedge clk) disable iff (rst)
        (soft_busy && $past(soft_busy)) |-> (user_irq == '0));

endmodule

// File: tb/ipc_mailbox_tb.sv
module ipc_mailbox_tb;

    localparam int N_USER = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [8:0]        bus_addr = '0;
    logic              bus_wr = 1'b0;
    logic [31:0]       bus_wdata = '0;
    logic              bus_rd = 1'b0;
    logic [31:0]       bus_rdata;
    logic [N_USER-1:0] user_irq;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    ipc_mailbox u_dut (
        .clk       (clk),
        .rst       (rst),
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .user_irq  (user_irq)
    );

    typedef struct packed {
        logic        rd;
        logic [8:0]  addr;
        logic [31:0] data;
        logic [3:0]  req;
    } vec_t;

    localparam int NV = 42;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 9'h0C0, 32'h0,  4'd1},  // R1 queue 0 empty
        '{1'b0, 9'h040, 32'hA1, 4'd3},  // R3 push
        '{1'b0, 9'h040, 32'hA2, 4'd3},
        '{1'b1, 9'h0C0, 32'h2,  4'd3},  // R3 level
        '{1'b1, 9'h100, 32'h1,  4'd5},  // R5 user 0 new msg
        '{1'b1, 9'h108, 32'h1,  4'd5},  // R5 user 1 new msg
        '{1'b1, 9'h040, 32'hA1, 4'd3},  // R3 order
        '{1'b1, 9'h040, 32'hA2, 4'd3},
        '{1'b1, 9'h040, 32'h0,  4'd4},  // R4 empty pop
        '{1'b1, 9'h0C0, 32'h0,  4'd4},
        '{1'b0, 9'h100, 32'h0,  4'd6},  // R6 zero write
        '{1'b1, 9'h100, 32'h1,  4'd6},
        '{1'b0, 9'h100, 32'h1,  4'd6},  // R6 clear
        '{1'b1, 9'h100, 32'h0,  4'd6},
        '{1'b1, 9'h108, 32'h1,  4'd6},  // R6 other user untouched
        '{1'b0, 9'h108, 32'h1,  4'd6},
        '{1'b0, 9'h048, 32'hB0, 4'd4},
        '{1'b0, 9'h048, 32'hB1, 4'd4},
        '{1'b0, 9'h048, 32'hB2, 4'd4},
        '{1'b0, 9'h048, 32'hB3, 4'd4},
        '{1'b0, 9'h048, 32'hB4, 4'd4},  // R4 dropped
        '{1'b1, 9'h0C8, 32'h4,  4'd4},
        '{1'b1, 9'h088, 32'h1,  4'd3},  // R3 full flag
        '{1'b1, 9'h048, 32'hB0, 4'd3},
        '{1'b1, 9'h088, 32'h0,  4'd3},
        '{1'b1, 9'h100, 32'h30, 4'd5},  // R5 interleaved bits 4 and 5
        '{1'b1, 9'h048, 32'hB1, 4'd3},
        '{1'b0, 9'h100, 32'h20, 4'd6},
        '{1'b1, 9'h100, 32'h10, 4'd6},
        '{1'b1, 9'h048, 32'hB2, 4'd3},
        '{1'b1, 9'h100, 32'h10, 4'd5},  // R5 no space event when not full
        '{1'b1, 9'h048, 32'hB3, 4'd3},
        '{1'b1, 9'h048, 32'h0,  4'd4},  // R4 fifth word was lost
        '{1'b1, 9'h000, 32'h10, 4'd1},  // R1 revision
        '{1'b1, 9'h020, 32'h0,  4'd2},  // R2 unmapped
        '{1'b1, 9'h118, 32'h0,  4'd2},
        '{1'b1, 9'h1F0, 32'h0,  4'd2},
        '{1'b0, 9'h000, 32'hFF, 4'd2},  // R2 read-only write
        '{1'b1, 9'h000, 32'h10, 4'd2},
        '{1'b0, 9'h010, 32'h19, 4'd9},  // R9 idle fields
        '{1'b1, 9'h010, 32'h19, 4'd9},
        '{1'b0, 9'h010, 32'hFFFFFFE5, 4'd9}
    };

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bus_write(input logic [8:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [8:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        @(negedge clk);
        bus_rd   = 1'b0;
        d        = bus_rdata;
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic [31:0] rv;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk("R1 irq", 32'(user_irq), 32'h0);
        bus_read(9'h014, rv); chk("R1 done", rv, 32'h1);
        bus_read(9'h104, rv); chk("R1 enable", rv, 32'h0);
        bus_read(9'h088, rv); chk("R1 full", rv, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VECS[i].rd) begin
                bus_read(VECS[i].addr, rv);
                chk($sformatf("R%0d vec %0d", VECS[i].req, i), rv, VECS[i].data);
            end else begin
                bus_write(VECS[i].addr, VECS[i].data);
            end
        end
        bus_read(9'h010, rv); chk("R9 other bits", rv, 32'h1);

        // R7 interrupt masking per user
        bus_write(9'h104, 32'h1);
        chk("R7 masked", 32'(user_irq), 32'h0);
        bus_write(9'h040, 32'hC1);
        chk("R7 user0 only", 32'(user_irq), 32'h1);
        bus_write(9'h10C, 32'h20);
        chk("R7 both", 32'(user_irq), 32'h3);
        bus_write(9'h100, 32'h1);
        chk("R6 R7 cleared user0", 32'(user_irq), 32'h2);

        // R8 soft reset timing and effect
        bus_write(9'h010, 32'h1A);
        for (int k = 0; k < 4; k++) begin
            bus_read(9'h014, rv); chk("R8 busy window", rv, 32'h0);
        end
        bus_read(9'h014, rv); chk("R8 done", rv, 32'h1);
        bus_read(9'h010, rv); chk("R8 R9 cfg after reset", rv, 32'h18);
        bus_read(9'h0C0, rv); chk("R8 queue emptied", rv, 32'h0);
        bus_read(9'h108, rv); chk("R8 status cleared", rv, 32'h0);
        bus_read(9'h10C, rv); chk("R8 enable cleared", rv, 32'h0);
        chk("R8 irq low", 32'(user_irq), 32'h0);

        // R10 registered read data
        bus_read(9'h000, rv); chk("R10 read", rv, 32'h10);
        @(negedge clk);
        chk("R10 hold", bus_rdata, 32'h10);
        bus_addr = 9'h014;
        bus_rd   = 1'b1;
        #1;
        chk("R10 before edge", bus_rdata, 32'h10);
        @(negedge clk);
        bus_rd = 1'b0;
        chk("R10 after edge", bus_rdata, 32'h1);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule